// File: doc/BRIEF.md
# Dual-Device Diagnostic Completion Combiner

This block merges the completion of two emulated drives, a master and a slave, while an execute-device-diagnostic command runs on a legacy ATA-style task file. Software starts the command with one pulse. Each drive then reports its own finish with a done pulse. The block drives the shared busy status bit and the interrupt request line.

The interrupt follows only the master's completion. Busy stays high until both drives have finished. As a result, the interrupt may assert while busy still reads 1 (the master finished first). Or busy may already be 0 when the interrupt appears (the slave finished first). The interrupt stays asserted until software reads the status register, which the block sees as a one-cycle read strobe.

Top module: `diag_done_combiner`

## Requirements
- R1: A synchronous active-high reset clears busy, the interrupt and both pending flags by the cycle after it is sampled, even in the middle of a command.
- R2: A start pulse sampled while busy is 0 sets both pending flags (pending bit 0 = master, bit 1 = slave) and busy to 1 at the next clock edge.
- R3: A start pulse sampled while busy is 1 is ignored. No pending flag is set again, and the drive that has already finished stays finished.
- R4: A done pulse for a pending drive clears that drive's pending flag at the next edge. A done pulse for a drive that is not pending changes nothing.
- R5: Busy reads 1 exactly while at least one drive is pending. It falls to 0 only at the edge where the last pending drive finishes.
- R6: The interrupt rises at the edge after the master's accepted done pulse, whatever the slave's state. If the slave is still pending, busy stays 1.
- R7: Once raised, the interrupt stays high until a status read strobe, which clears it at the next edge. If a read strobe coincides with an accepted master done, the interrupt is set.
- R8: The slave's completion never raises the interrupt. The interrupt asserts at most once per command, because a repeated master done pulse is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| diag_start | input | 1 | One-cycle pulse starting the diagnostic command |
| dev_done | input | 2 | Per-drive completion pulses, bit 0 master, bit 1 slave |
| status_rd | input | 1 | One-cycle strobe for a status-register read |
| busy | output | 1 | Shared busy status bit |
| intr | output | 1 | Interrupt request |
| pending | output | 2 | Per-drive pending flags, bit 0 master, bit 1 slave |

## Verification
The hardest situations to reach are collisions: a start pulse that lands while one drive is finished and the other is still pending, a master done that repeats after the interrupt was serviced, and a read strobe that arrives in the very cycle the master completes. The directed tasks build each one deliberately. They first park the block in the partial state with one drive finished, then issue the colliding pulses in a single cycle. Busy, pending and intr are checked at the edge right after.

// File: rtl/diag_pkg.sv
package diag_pkg;

    localparam int DEV_COUNT  = 2;
    localparam int MASTER_IDX = 0;
    localparam int SLAVE_IDX  = 1;

    typedef logic [DEV_COUNT-1:0] dev_mask_t;

    typedef struct packed {
        logic busy;
        logic intr;
    } diag_status_t;

    function automatic logic any_pending(input dev_mask_t m);
        return |m;
    endfunction

endpackage

// File: rtl/diag_dev_slot.sv
module diag_dev_slot (
    input  logic clk,
    input  logic rst,
    input  logic start_accept,
    input  logic done_pulse,
    output logic pending_q,
    output logic pending_d
);

    always_comb begin
        pending_d = pending_q;
        if (start_accept)
            pending_d = 1'b1;
        else if (done_pulse && pending_q)
            pending_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pending_q <= 1'b0;
        else
            pending_q <= pending_d;
    end

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (done_pulse && pending_q && !start_accept) |=> !pending_q); // R4

    AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!pending_q && !start_accept) |=> !pending_q); // R4

endmodule

// File: rtl/diag_irq_ctrl.sv
module diag_irq_ctrl
    import diag_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  dev_mask_t    pend_next,
    input  logic         master_accept,
    input  logic         slave_accept,
    input  logic         status_rd,
    output diag_status_t stat_q
);

    diag_status_t stat_d;

    always_comb begin
        stat_d.busy = any_pending(pend_next);
        stat_d.intr = stat_q.intr;
        if (master_accept)
            stat_d.intr = 1'b1;
        else if (status_rd)
            stat_d.intr = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            stat_q <= '0;
        else
            stat_q <= stat_d;
    end

    AST_INTR_FROM_MASTER: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q.intr) |-> $past(master_accept)); // R6

    AST_INTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (stat_q.intr && !status_rd) |=> stat_q.intr); // R7

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (status_rd && !master_accept) |=> !stat_q.intr); // R7

    AST_SLAVE_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        (slave_accept && !master_accept && !stat_q.intr) |=> !stat_q.intr); // R8

endmodule

// File: rtl/diag_done_combiner.sv
module diag_done_combiner
    import diag_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 diag_start,
    input  logic [DEV_COUNT-1:0] dev_done,
    input  logic                 status_rd,
    output logic                 busy,
    output logic                 intr,
    output logic [DEV_COUNT-1:0] pending
);

    dev_mask_t    pend_q;
    dev_mask_t    pend_d;
    diag_status_t stat;
    logic         start_accept;

    assign start_accept = diag_start && !stat.busy;

    for (genvar g = 0; g < DEV_COUNT; g++) begin : g_slot
        diag_dev_slot u_slot (
            .clk          (clk),
            .rst          (rst),
            .start_accept (start_accept),
            .done_pulse   (dev_done[g]),
            .pending_q    (pend_q[g]),
            .pending_d    (pend_d[g])
        );
    end

    diag_irq_ctrl u_irq (
        .clk           (clk),
        .rst           (rst),
        .pend_next     (pend_d),
        .master_accept (dev_done[MASTER_IDX] && pend_q[MASTER_IDX]),
        .slave_accept  (dev_done[SLAVE_IDX] && pend_q[SLAVE_IDX]),
        .status_rd     (status_rd),
        .stat_q        (stat)
    );

    assign busy    = stat.busy;
    assign intr    = stat.intr;
    assign pending = pend_q;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!busy && !intr && pending == '0)); // R1

    AST_START_SETS: assert property (@(posedge clk) disable iff (rst)
        (diag_start && !busy) |=> (busy && pending == '1)); // R2

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        busy |=> ((pending & ~$past(pending)) == '0)); // R3

    AST_BUSY_MATCH: assert property (@(posedge clk) disable iff (rst)
        busy == (pending != '0)); // R5

endmodule

// File: tb/diag_done_combiner_bench.sv
module diag_done_combiner_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       diag_start;
    logic [1:0] dev_done;
    logic       status_rd;
    logic       busy;
    logic       intr;
    logic [1:0] pending;

    int checks = 0;
    int errors = 0;
    bit summary_done = 1'b0;

    always #2.5 clk = ~clk;

    diag_done_combiner u_diag_done_combiner (
        .clk        (clk),
        .rst        (rst),
        .diag_start (diag_start),
        .dev_done   (dev_done),
        .status_rd  (status_rd),
        .busy       (busy),
        .intr       (intr),
        .pending    (pending)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {busy,intr,pending} actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic expect_state(input string req, input logic b, input logic i, input logic [1:0] p);
        check(req, {busy, intr, pending}, {b, i, p});
    endtask

    // apply inputs for one cycle, then sample just after the edge
    task automatic step(input logic s, input logic [1:0] d, input logic r);
        diag_start = s;
        dev_done   = d;
        status_rd  = r;
        @(posedge clk);
        #1;
        diag_start = 1'b0;
        dev_done   = 2'b00;
        status_rd  = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(1'b0, 2'b00, 1'b0);
        step(1'b0, 2'b00, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        expect_state("R1 idle after reset", 1'b0, 1'b0, 2'b00);
        step(1'b1, 2'b00, 1'b0);
        step(1'b0, 2'b01, 1'b0);
        rst = 1'b1;
        step(1'b0, 2'b00, 1'b0);
        rst = 1'b0;
        expect_state("R1 reset mid-command", 1'b0, 1'b0, 2'b00);
    endtask

    task automatic t_master_first();
        do_reset();
        step(1'b1, 2'b00, 1'b0);
        expect_state("R2 start sets both pending", 1'b1, 1'b0, 2'b11);
        step(1'b0, 2'b01, 1'b0);
        expect_state("R6 master first raises intr, busy held", 1'b1, 1'b1, 2'b10);
        step(1'b0, 2'b00, 1'b0);
        expect_state("R7 intr held without read", 1'b1, 1'b1, 2'b10);
        step(1'b0, 2'b10, 1'b0);
        expect_state("R5 busy falls when slave finishes", 1'b0, 1'b1, 2'b00);
        step(1'b0, 2'b00, 1'b1);
        expect_state("R7 status read clears intr", 1'b0, 1'b0, 2'b00);
    endtask

    task automatic t_slave_first();
        do_reset();
        step(1'b1, 2'b00, 1'b0);
        step(1'b0, 2'b10, 1'b0);
        expect_state("R8 slave done gives no intr", 1'b1, 1'b0, 2'b01);
        step(1'b0, 2'b01, 1'b0);
        expect_state("R6 master last: busy 0 with intr", 1'b0, 1'b1, 2'b00);
    endtask

    task automatic t_both_same();
        do_reset();
        step(1'b1, 2'b00, 1'b0);
        step(1'b0, 2'b11, 1'b0);
        expect_state("R5 both done together", 1'b0, 1'b1, 2'b00);
    endtask

    task automatic t_ignored();
        do_reset();
        step(1'b0, 2'b11, 1'b0);
        expect_state("R4 done while idle ignored", 1'b0, 1'b0, 2'b00);
        step(1'b1, 2'b00, 1'b0);
        step(1'b0, 2'b01, 1'b0);
        step(1'b1, 2'b00, 1'b0);
        expect_state("R3 restart while busy ignored", 1'b1, 1'b1, 2'b10);
        step(1'b0, 2'b00, 1'b1);
        expect_state("R7 read clears intr while busy", 1'b1, 1'b0, 2'b10);
        step(1'b0, 2'b01, 1'b0);
        expect_state("R8 repeated master done no second intr", 1'b1, 1'b0, 2'b10);
        step(1'b0, 2'b10, 1'b0);
        expect_state("R4 slave done clears its flag", 1'b0, 1'b0, 2'b00);
    endtask

    task automatic t_read_collide();
        do_reset();
        step(1'b1, 2'b00, 1'b0);
        step(1'b0, 2'b01, 1'b1);
        expect_state("R7 read colliding with master done keeps intr", 1'b1, 1'b1, 2'b10);
        step(1'b0, 2'b10, 1'b0);
        step(1'b1, 2'b00, 1'b0);
        expect_state("R2 new command after finish", 1'b1, 1'b1, 2'b11);
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        rst        = 1'b1;
        diag_start = 1'b0;
        dev_done   = 2'b00;
        status_rd  = 1'b0;
        t_reset();
        t_master_first();
        t_slave_first();
        t_both_same();
        t_ignored();
        t_read_collide();
        finish_run();
    end

    initial begin
        #(5 * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule